// File: doc/BRIEF.md
# Receive Collision Event Counter

This block keeps a running 16-bit tally of the collisions a network receiver reports. Each single-cycle collision pulse adds one to the tally. When the tally passes its top value it rolls back to zero and sets a sticky overflow flag. The flag stays set until the host issues a write-one clear strobe. The tally is presented on a 32-bit read port. The count sits in the low half and the high half is driven to zero.

Host register writes normally leave the tally alone, whatever data they carry. When the test-enable level is high, every write strobe acts as one extra increment, so the wrap path can be reached quickly. The tally returns to zero on a hard reset, on a soft reset, and for as long as the STOP level is high. The overflow flag clears only on the two resets or on the clear strobe.

Top module: `rx_coll_counter`

## Requirements
- R1: After a hard reset or a soft reset the count reads 0 and the overflow flag reads 0.
- R2: A collision pulse with no clear condition active raises the count by exactly one in the following cycle.
- R3: An increment from 65535 (16'hFFFF) yields a count of 0.
- R4: Every carry out of the 16-bit count sets the overflow flag in the next cycle. The flag then holds at 1 while no clear source is present.
- R5: A pulse on the overflow clear strobe drops the flag to 0 in the next cycle, unless a wrap occurs in that same cycle. When both happen, the set wins.
- R6: A write strobe with test-enable low leaves the count unchanged, whatever the 32-bit write data.
- R7: A write strobe with test-enable high raises the count by one, whatever the write data. Test-enable alone, with no strobe, has no effect.
- R8: While STOP is high the count is held at 0 and collision pulses are discarded. STOP does not clear the overflow flag.
- R9: A collision pulse and a test-mode write in the same cycle raise the count by two. A carry out of that double step is detected: 65534 goes to 0 and 65535 goes to 1, and both set the flag.
- R10: The read port always carries the count in bits 15..0 and zero in bits 31..16, including while STOP is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| hard_rst_i | input | 1 | Synchronous active-high hard reset |
| soft_rst_i | input | 1 | Synchronous active-high soft reset |
| stop_i | input | 1 | STOP level; holds the count at zero |
| test_en_i | input | 1 | Test-mode enable level |
| coll_i | input | 1 | Single-cycle collision pulse from the receiver |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data (ignored by the count) |
| ovf_clr_i | input | 1 | Write-one clear strobe for the overflow flag |
| rd_data_o | output | 32 | Read data: count in bits 15..0, zero above |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The increment path is driven by lone collision pulses, lone write strobes with test-enable low and then high, and strobes that coincide with collisions. These separate the ignored write, the single step and the double step. Write data is varied between all-zeros and all-ones to show that it never reaches the count. STOP is applied with and without collisions to tell holding apart from a one-cycle clear, and it is applied while the flag is set to show that the flag survives. The wrap is reached from 65535 with a single step, and from both 65534 and 65535 with a double step. These cases expose a carry lost in the sum or a flag that the clear strobe overrides.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  // Number of increment sources: collision pulse and test-mode write.
  localparam int N_SRC  = 2;
  localparam int STEP_W = $clog2(N_SRC + 1);
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/rcc_step_sel.sv
module rcc_step_sel
  import rcc_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic [NS-1:0] src_i,
  output step_t         step_o
);
  // Population count of the active increment sources.
  always_comb begin
    step_o = '0;
    for (int k = 0; k < NS; k++) begin
      step_o = step_o + step_t'(src_i[k]);
    end
  end
endmodule

// File: rtl/rcc_count_core.sv
module rcc_count_core
  import rcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             clr_i,
  input  step_t            step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q;
  logic [SUM_W-1:0] sum;

  assign sum    = {1'b0, count_q} + SUM_W'(step_i);
  assign wrap_o = sum[CNT_W] & ~clr_i;

  always_ff @(posedge clk) begin
    if (clr_i) count_q <= '0;
    else       count_q <= sum[CNT_W-1:0];
  end

  assign count_o = count_q;

  // R2: one source active -> count advances by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst_i)
    (!clr_i && step_i == step_t'(1)) |=> count_q == CNT_W'($past(count_q) + 1'b1));

  // R3: a count of all ones plus one lands on zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst_i)
    (!clr_i && step_i == step_t'(1) && &count_q) |=> count_q == '0);

  // R9: two sources active -> count advances by two
  a_r9_double_step: assert property (@(posedge clk) disable iff (rst_i)
    (!clr_i && step_i == step_t'(2)) |=> count_q == CNT_W'($past(count_q) + 2'd2));
endmodule

// File: rtl/rcc_ovf_flag.sv
module rcc_ovf_flag (
  input  logic clk,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst_i)      flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R4: a wrap sets the flag
  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (rst_i)
    set_i |=> flag_q);

  // R4: flag holds without a clear
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst_i)
    (flag_q && !clr_i) |=> flag_q);

  // R5: clear strobe without a wrap drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (rst_i)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/rx_coll_counter.sv
module rx_coll_counter
  import rcc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              hard_rst_i,
  input  logic              soft_rst_i,
  input  logic              stop_i,
  input  logic              test_en_i,
  input  logic              coll_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ovf_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             any_rst;
  logic             cnt_clr;
  logic             test_wr;
  logic [N_SRC-1:0] srcs;
  step_t            step;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             unused_data;

  assign any_rst     = hard_rst_i | soft_rst_i;
  assign cnt_clr     = any_rst | stop_i;
  assign test_wr     = wr_en_i & test_en_i;
  assign srcs        = {test_wr, coll_i};
  assign unused_data = ^wr_data_i;

  rcc_step_sel #(.NS(N_SRC)) u_step (
    .src_i  (srcs),
    .step_o (step)
  );

  rcc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_i   (any_rst),
    .clr_i   (cnt_clr),
    .step_i  (step),
    .count_o (count),
    .wrap_o  (wrap)
  );

  rcc_ovf_flag u_flag (
    .clk    (clk),
    .rst_i  (any_rst),
    .set_i  (wrap),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o = {{PAD_W{1'b0}}, count};
    end else begin : g_nopad
      assign rd_data_o = count[DATA_W-1:0];
    end
  endgenerate

  // R1: either reset clears count and flag
  a_r1_reset: assert property (@(posedge clk)
    any_rst |=> (count == '0 && !ovf_o));

  // R8: STOP forces the count to zero
  a_r8_stop_zero: assert property (@(posedge clk) disable iff (any_rst)
    stop_i |=> count == '0);

  // R8: STOP leaves the flag alone when no clear strobe is present
  a_r8_stop_keeps_flag: assert property (@(posedge clk) disable iff (any_rst)
    (stop_i && ovf_o && !ovf_clr_i) |=> ovf_o);

  // R6: plain write has no effect on the count
  a_r6_plain_write: assert property (@(posedge clk) disable iff (any_rst)
    (!stop_i && wr_en_i && !test_en_i && !coll_i) |=> $stable(count));

  // R7: test-mode write alone advances by one
  a_r7_test_write: assert property (@(posedge clk) disable iff (any_rst)
    (!stop_i && wr_en_i && test_en_i && !coll_i) |=> count == CNT_W'($past(count) + 1'b1));
endmodule

// File: tb/test_rx_coll_counter.sv
`timescale 1ns/1ps
module test_rx_coll_counter;
  logic        clk = 1'b0;
  logic        hard_rst, soft_rst, stop, test_en, coll, wr_en, ovf_clr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  rx_coll_counter i_rx_coll_counter (
    .clk(clk), .hard_rst_i(hard_rst), .soft_rst_i(soft_rst), .stop_i(stop),
    .test_en_i(test_en), .coll_i(coll), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ovf_clr_i(ovf_clr), .rd_data_o(rd_data), .ovf_o(ovf)
  );

  // vector: coll, wr, test, stop, clr, soft, exp_cnt[16], exp_ovf
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {6'b100000, 16'd1, 1'b0},  // R2
    {6'b100000, 16'd2, 1'b0},  // R2
    {6'b010000, 16'd2, 1'b0},  // R6
    {6'b011000, 16'd3, 1'b0},  // R7
    {6'b111000, 16'd5, 1'b0},  // R9
    {6'b001000, 16'd5, 1'b0},  // R7 test level alone
    {6'b000100, 16'd0, 1'b0},  // R8
    {6'b100100, 16'd0, 1'b0},  // R8 collisions discarded
    {6'b100000, 16'd1, 1'b0},  // R2
    {6'b000001, 16'd0, 1'b0},  // R1 soft reset
    {6'b110000, 16'd1, 1'b0},  // R6 write ignored beside collision
    {6'b000010, 16'd1, 1'b0}   // R5 clear with no flag
  };

  task automatic drive(input bit c, input bit w, input bit t, input bit s,
                       input bit cl, input bit sr, input logic [31:0] d);
    @(negedge clk);
    coll = c; wr_en = w; test_en = t; stop = s; ovf_clr = cl; soft_rst = sr;
    wr_data = d;
    @(negedge clk);
    coll = 0; wr_en = 0; test_en = 0; stop = 0; ovf_clr = 0; soft_rst = 0;
  endtask

  task automatic check(input string req, input logic [15:0] ec, input bit eo);
    n_tests++;
    if (rd_data !== {16'h0, ec} || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: rd=%h ovf=%b expected rd=%h ovf=%b", req, rd_data, ovf,
               {16'h0, ec}, eo);
    end
  endtask

  // Drive double steps to reach 65534 from zero.
  task automatic climb();
    @(negedge clk);
    coll = 1; wr_en = 1; test_en = 1;
    for (int k = 0; k < 32767; k++) @(negedge clk);
    coll = 0; wr_en = 0; test_en = 0;
  endtask

  initial begin
    hard_rst = 1; soft_rst = 0; stop = 0; test_en = 0; coll = 0;
    wr_en = 0; ovf_clr = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    hard_rst = 0;
    check("R1", 16'd0, 1'b0);
    check("R10", 16'd0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][22], VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18],
            VEC[v][17], (v % 2) ? 32'hFFFF_FFFF : 32'h0);
      check($sformatf("R10 vec%0d", v), VEC[v][16:1], VEC[v][0]);
    end

    // reset to zero, then double-step wrap from 65534
    drive(0, 0, 0, 1, 0, 0, 0);
    climb();
    check("R9 reach 65534", 16'd65534, 1'b0);
    drive(1, 1, 1, 0, 0, 0, 32'hDEAD_BEEF);
    check("R9 65534+2", 16'd0, 1'b1);
    drive(1, 0, 0, 0, 0, 0, 0);
    check("R4 sticky", 16'd1, 1'b1);
    drive(0, 0, 0, 1, 0, 0, 0);
    check("R8 stop keeps flag", 16'd0, 1'b1);
    drive(0, 0, 0, 0, 1, 0, 0);
    check("R5 clear", 16'd0, 1'b0);

    // single-step wrap from 65535
    climb();
    drive(1, 0, 0, 0, 0, 0, 0);
    check("R2 to 65535", 16'd65535, 1'b0);
    drive(1, 0, 0, 0, 0, 0, 0);
    check("R3 wrap", 16'd0, 1'b1);
    drive(0, 1, 0, 0, 0, 0, 32'hFFFF_FFFF);
    check("R6 write while flagged", 16'd0, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 0);
    check("R1 soft reset clears flag", 16'd0, 1'b0);

    // double-step wrap from 65535
    climb();
    drive(1, 0, 0, 0, 0, 0, 0);
    check("R9 at 65535", 16'd65535, 1'b0);
    drive(1, 1, 1, 0, 1, 0, 0);
    check("R9 65535+2 set beats clear R5", 16'd1, 1'b1);
    @(negedge clk);
    hard_rst = 1;
    @(negedge clk);
    hard_rst = 0;
    check("R1 hard reset", 16'd0, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule